// File: doc/BRIEF.md
# Write Completion Status Reader

This block answers host read cycles on a parallel memory port while a self-timed program cycle may be running. When the memory is idle, a read returns the stored byte supplied by the array model. While the memory is busy, the stored byte is not available. The read instead returns a status word that gives two in-band ways to detect completion.

The first is a complement poll. A read of the address written last returns the inverse of that byte's most significant bit. The second is a toggle bit in bit position 6, which inverts on each new read access for as long as the cycle runs.

The data output is gated against bus contention. It is driven only during a genuine read access. Controls are sampled on the rising clock edge, and the data word and its drive enable are registered, so both appear one cycle after the access is presented. The indeterminate status bits are defined as zero.

Top module: `wrstat_reader`

## Requirements
- R1: One cycle after `cs_n`=0, `rd_oe_n`=0 and `wr_n`=1 are sampled, `dout_en` is 1.
- R2: One cycle after `cs_n`=1 or `rd_oe_n`=1 is sampled, `dout_en` is 0 and `dout` is 8'h00.
- R3: While `wr_n`=0, `dout_en` stays 0 and `dout` stays 8'h00 even with `cs_n` and `rd_oe_n` both low.
- R4: A read with `busy`=1 and `rd_addr`==`last_addr` returns bit 7 equal to the inverse of `last_wr_msb`.
- R5: A busy read returns bits 5..0 as zero, and returns bit 7 as zero when `rd_addr` differs from `last_addr`.
- R6: During a busy period, the first read access returns bit 6 = 1. Each later access, marked by a new falling edge of `rd_oe_n` with `cs_n`=0 and `wr_n`=1, inverts bit 6. Holding `rd_oe_n` low keeps the value.
- R7: A rising edge of `busy` resets the toggle, so the first read of every new program cycle returns bit 6 = 1 whatever the previous cycle left.
- R8: A read with `busy`=0 returns `arr_data` unchanged, as presented in the sampled cycle.
- R9: A falling edge of `rd_oe_n` while `cs_n`=1 is not a read access and does not advance the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_addr | input | 13 | Read address |
| busy | input | 1 | Program cycle in progress |
| last_addr | input | 13 | Address of the byte written last |
| last_wr_msb | input | 1 | Bit 7 of the byte written last |
| arr_data | input | 8 | Stored byte at `rd_addr` from the array model |
| dout | output | 8 | Registered read data, zero when not driven |
| dout_en | output | 1 | Registered output drive enable |

## Verification
Idle reads at several addresses against a computed array pattern show that the true data path is untouched when `busy` is low. Busy reads at the matching address with both values of the last written bit separate the complement poll from a plain copy. Reads at a different address separate address matching from an unconditional poll. A run of consecutive busy reads, including one that holds `rd_oe_n` low for two cycles and one pulse of `rd_oe_n` with `cs_n` high, distinguishes edge-counted toggling from level- or strobe-driven toggling. A second program cycle that begins with the toggle at 1 shows whether it is reset at the start of each cycle.

// File: rtl/wrstat_pkg.sv
package wrstat_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wrstat_busgate.sv
module wrstat_busgate (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_oe_n,
  input  logic wr_n,
  output logic rd_ok,
  output logic access_start
);
  logic oe_n_q;

  assign rd_ok        = !cs_n && !rd_oe_n && wr_n;
  assign access_start = oe_n_q && rd_ok;

  always_ff @(posedge clk) begin
    if (rst) oe_n_q <= 1'b1;
    else     oe_n_q <= rd_oe_n;
  end

  // R9: deselected strobes never count as accesses
  a_r9_no_access_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !access_start);
  // R6: an access start needs the enable high in the prior cycle
  a_r6_start_is_edge: assert property (@(posedge clk) disable iff (rst)
    access_start |-> $past(rd_oe_n));
endmodule

// File: rtl/wrstat_toggle.sv
module wrstat_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic access_start,
  output logic tog_now
);
  logic busy_q;
  logic tog_q;
  logic busy_rise;
  logic flip;
  logic base;

  assign busy_rise = busy && !busy_q;
  assign flip      = busy && access_start;
  assign base      = busy_rise ? 1'b0 : tog_q;
  assign tog_now   = base ^ flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      tog_q  <= tog_now;
    end
  end

  // R6: a busy access inverts the toggle
  a_r6_flip_on_access: assert property (@(posedge clk) disable iff (rst)
    (flip && !busy_rise) |=> (tog_q != $past(tog_q)));
  // R7: start of a program cycle without an access clears the toggle
  a_r7_reload_on_start: assert property (@(posedge clk) disable iff (rst)
    (busy_rise && !flip) |=> !tog_q);
  // R6: no access, no change
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!flip && !busy_rise) |=> $stable(tog_q));
endmodule

// File: rtl/wrstat_mux.sv
module wrstat_mux
  import wrstat_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              rd_ok,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              last_wr_msb,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              tog_now,
  output logic [DATA_W-1:0] word
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  rd_src_e           src;
  logic [DATA_W-1:0] status_w;
  logic              hit;

  assign hit = (rd_addr == last_addr);

  always_comb begin
    status_w           = '0;
    status_w[TOG_BIT]  = tog_now;
    status_w[POLL_BIT] = hit ? !last_wr_msb : 1'b0;
  end

  always_comb begin
    if (!rd_ok)    src = SRC_NONE;
    else if (busy) src = SRC_STATUS;
    else           src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY:  word = arr_data;
      SRC_STATUS: word = status_w;
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/wrstat_reader.sv
module wrstat_reader #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              last_wr_msb,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int LOW_W    = DATA_W - 2;

  logic              rd_ok;
  logic              access_start;
  logic              tog_now;
  logic [DATA_W-1:0] word;

  wrstat_busgate u_gate (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_oe_n(rd_oe_n), .wr_n(wr_n),
    .rd_ok(rd_ok), .access_start(access_start)
  );

  wrstat_toggle u_tog (
    .clk(clk), .rst(rst), .busy(busy), .access_start(access_start),
    .tog_now(tog_now)
  );

  wrstat_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .rd_ok(rd_ok), .busy(busy), .rd_addr(rd_addr), .last_addr(last_addr),
    .last_wr_msb(last_wr_msb), .arr_data(arr_data), .tog_now(tog_now),
    .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= word;
      dout_en <= rd_ok;
    end
  end

  // R1
  a_r1_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_oe_n && wr_n) |=> dout_en);
  // R2
  a_r2_release_bus: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_oe_n) |=> (!dout_en && dout == '0));
  // R3
  a_r3_no_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (!dout_en && dout == '0));
  // R4
  a_r4_complement_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && busy && rd_addr == last_addr) |=> (dout[POLL_BIT] == !$past(last_wr_msb)));
  // R5
  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && busy) |=> (dout[LOW_W-1:0] == '0));
  // R8
  a_r8_true_data_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !busy) |=> (dout == $past(arr_data)));
endmodule

// File: tb/test_wrstat_reader.sv
module test_wrstat_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_oe_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [12:0] rd_addr = '0;
  logic        busy = 1'b0;
  logic [12:0] last_addr = '0;
  logic        last_wr_msb = 1'b0;
  logic [7:0]  arr_data;
  logic [7:0]  dout;
  logic        dout_en;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = !clk;

  // array model: a computed pattern per address
  assign arr_data = rd_addr[7:0] ^ {rd_addr[12:8], 3'b101} ^ 8'h3C;

  wrstat_reader i_wrstat_reader (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_oe_n(rd_oe_n), .wr_n(wr_n),
    .rd_addr(rd_addr), .busy(busy), .last_addr(last_addr),
    .last_wr_msb(last_wr_msb), .arr_data(arr_data),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got en/data %h expected %h", req, act, exp);
    end
  endtask

  // one read access: select, strobe, sample one or two cycles, release
  task automatic rd(input logic [12:0] a, input logic [7:0] exp, input string req, input bit hold);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b1; rd_addr = a;
    @(negedge clk); rd_oe_n = 1'b0;
    @(negedge clk); check(req, {dout_en, dout}, {1'b1, exp});
    if (hold) begin
      @(negedge clk); check({req, " hold"}, {dout_en, dout}, {1'b1, exp});
    end
    rd_oe_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk);
    check("reset", {dout_en, dout}, 9'h000);
    rst = 1'b0;
  endtask

  task automatic t_idle_reads;  // R8, R1
    rd(13'h0000, pat(13'h0000), "R8 idle addr 0", 1'b0);
    rd(13'h1FFF, pat(13'h1FFF), "R8 idle top addr", 1'b0);
    rd(13'h0A5C, pat(13'h0A5C), "R1 idle read drives", 1'b0);
  endtask

  task automatic t_gating;  // R2, R3
    @(negedge clk); cs_n = 1'b0; rd_oe_n = 1'b1; wr_n = 1'b1; rd_addr = 13'h0011;
    @(negedge clk); check("R2 oe high", {dout_en, dout}, 9'h000);
    cs_n = 1'b1; rd_oe_n = 1'b0;
    @(negedge clk); check("R2 cs high", {dout_en, dout}, 9'h000);
    cs_n = 1'b0; rd_oe_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); check("R3 write strobe low", {dout_en, dout}, 9'h000);
    cs_n = 1'b1; rd_oe_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); check("R2 released", {dout_en, dout}, 9'h000);
  endtask

  task automatic t_busy_cycle_a;  // R4, R5, R6, R9
    @(negedge clk); last_addr = 13'h0123; last_wr_msb = 1'b1; busy = 1'b1;
    rd(13'h0123, 8'h40, "R4 R6 first poll", 1'b0);
    rd(13'h0123, 8'h00, "R6 second poll", 1'b0);
    rd(13'h0456, 8'h40, "R5 other addr", 1'b1);
    // strobe while deselected: not an access
    @(negedge clk); cs_n = 1'b1; rd_oe_n = 1'b0;
    @(negedge clk); rd_oe_n = 1'b1;
    @(negedge clk); check("R9 no drive deselected", {dout_en, dout}, 9'h000);
    rd(13'h0123, 8'h00, "R9 toggle not advanced", 1'b0);
    rd(13'h0123, 8'h40, "R6 third flip", 1'b0);
  endtask

  task automatic t_busy_end;  // R8
    @(negedge clk); busy = 1'b0;
    rd(13'h0123, pat(13'h0123), "R8 after busy", 1'b0);
  endtask

  task automatic t_busy_cycle_b;  // R7, R4
    @(negedge clk); last_addr = 13'h1ABC; last_wr_msb = 1'b0; busy = 1'b1;
    rd(13'h1ABC, 8'hC0, "R7 reload and R4 poll", 1'b0);
    rd(13'h1ABC, 8'h80, "R6 flip cycle b", 1'b0);
    @(negedge clk); busy = 1'b0;
    rd(13'h1ABC, pat(13'h1ABC), "R8 cycle b done", 1'b0);
  endtask

  initial begin
    t_reset;
    t_idle_reads;
    t_gating;
    t_busy_cycle_a;
    t_busy_end;
    t_busy_cycle_b;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule